// File: doc/BRIEF.md
# Single-Line Serial Bus Master (reset, byte write, byte read)

This block is the master for a single-wire, open-drain serial bus: one data line that an external resistor pulls up. Any party on the bus may pull the line low. The block never drives the line high. Its one output enable, `bus_pull_o`, tells the pad to pull low when it is 1 and to release the line when it is 0. The block reads the line back through `bus_i`.

A host requests a transaction with a one-cycle `start_i` strobe and a two-bit operation code. The block supports three transactions:
- A bus reset that also reports whether any device answered with a presence pulse.
- A byte write, sent as eight timed slots.
- A byte read, received as eight timed slots.

Every duration is set in microseconds and converted to clock cycles from the `CLK_HZ` parameter. Each bit has a fixed-length slot, and a short released recovery gap separates one slot from the next. When a transaction finishes, the block raises `busy_o` low again and gives a single-cycle `done_o` pulse. In that same cycle the read byte or the presence result appears on its output.

Top module: `onewire_master`

## Requirements
- R1: A reset operation (op code 2'b00) pulls the line low for exactly RST_LOW_US (default 480 µs) and then releases it.
- R2: After the reset release, the synchronised line is sampled PRES_SAMPLE_US (default 60 µs) later. If the line is low there, `presence_o` is 1; otherwise it is 0. `done_o` fires PRES_TAIL_US (default 420 µs) after the sample.
- R3: Every write slot (op code 2'b01) starts by pulling the line low. A 1 bit releases the line after WR1_LOW_US (default 2 µs). A 0 bit holds the line low for SLOT_US (default 60 µs). From the start of one slot to the start of the next is at least SLOT_US.
- R4: A read slot (op code 2'b10) pulls the line low for RD_LOW_US (default 2 µs) and then releases it. The line is sampled RD_SAMPLE_US (default 5 µs) after the release. The slot then stays released for SLOT_US minus RD_SAMPLE_US, so the slot lasts at least SLOT_US.
- R5: Each byte uses exactly eight slots, least significant bit first. A bit read as high becomes a 1 in `rd_data_o`.
- R6: Between consecutive slots the line stays released for at least RECOV_US (default 5 µs).
- R7: The block only pulls low or releases. While the block is idle, `bus_pull_o` is 0.
- R8: A `start_i` strobe while `busy_o` is 1 has no effect. A start with op code 2'b11 starts nothing.
- R9: `done_o` is high for exactly one cycle, and `busy_o` falls in that same cycle. `rd_data_o` changes only in the done cycle of a read. `presence_o` changes only in the done cycle of a reset.
- R10: After the synchronous reset, `busy_o`, `done_o`, `bus_pull_o`, `presence_o` and `rd_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle transaction request |
| op_i | input | 2 | 00 reset, 01 write byte, 10 read byte, 11 none |
| wr_data_i | input | DATA_W | Byte to write, captured with start_i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | DATA_W | Last byte read |
| presence_o | output | 1 | Result of the last reset |
| bus_pull_o | output | 1 | 1 = pull line low, 0 = release |
| bus_i | input | 1 | Line level seen at the pad |

## Verification
The assertions check the handshake rules on every cycle:
- `done_o` lasts a single cycle, and `busy_o` falls only with it.
- The result outputs move only in a done cycle.
- The line is never pulled while the block is idle.
- The bit shifter is never advanced past a full byte.
- The slot timer parks at zero once it expires.

Line timing and data content need a bench device model that answers on the wire, so only the bench scenarios can show them. That covers the measured widths of the reset pulse and of each write slot, slot spacing and recovery gaps, bit order on the line, presence detection with and without a device, and the read byte.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } ow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_RST_TAIL,
    ST_BIT_LOW,
    ST_RD_WAIT,
    ST_BIT_HIGH,
    ST_RECOV
  } ow_state_e;

  // states in which the master holds the wire low
  function automatic logic pulls_low(ow_state_e s);
    return (s == ST_RST_LOW) || (s == ST_BIT_LOW);
  endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // reset to 1: an idle wire rests high through the pull-up
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ow_timer.sv
module ow_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // once expired, the timer stays expired until reloaded (phase lengths, R1)
  assert_timer_parks_R1: assert property (@(posedge clk) disable iff (rst)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/ow_shifter.sv
module ow_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [BITS-1:0] load_val_i,
  input  logic            shift_i,
  input  logic            in_bit_i,
  output logic            lsb_o,
  output logic            full_o,
  output logic [BITS-1:0] data_o
);
  localparam int CW = $clog2(BITS + 1);

  logic [BITS-1:0] sr_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= load_val_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      // bits leave and arrive at the low end first
      sr_q  <= {in_bit_i, sr_q[BITS-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lsb_o  = sr_q[0];
  assign full_o = (cnt_q == CW'(BITS));
  assign data_o = sr_q;

  // the sequencer never requests a ninth slot (R5)
  assert_no_overshift_R5: assert property (@(posedge clk) disable iff (rst)
    shift_i |-> !full_o);
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 60,
  parameter int PRES_TAIL_US   = 420,
  parameter int SLOT_US        = 60,
  parameter int WR1_LOW_US     = 2,
  parameter int RD_LOW_US      = 2,
  parameter int RD_SAMPLE_US   = 5,
  parameter int RECOV_US       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              presence_o,
  output logic              bus_pull_o,
  input  logic              bus_i
);
  localparam int CYC_US      = CLK_HZ / 1_000_000;
  localparam int C_RST_LOW   = RST_LOW_US * CYC_US;
  localparam int C_PRES_SMP  = PRES_SAMPLE_US * CYC_US;
  localparam int C_PRES_TAIL = PRES_TAIL_US * CYC_US;
  localparam int C_SLOT      = SLOT_US * CYC_US;
  localparam int C_WR1_LOW   = WR1_LOW_US * CYC_US;
  localparam int C_WR1_HIGH  = (SLOT_US - WR1_LOW_US) * CYC_US;
  localparam int C_RD_LOW    = RD_LOW_US * CYC_US;
  localparam int C_RD_SMP    = RD_SAMPLE_US * CYC_US;
  localparam int C_RD_TAIL   = (SLOT_US - RD_SAMPLE_US) * CYC_US;
  localparam int C_RECOV     = RECOV_US * CYC_US;
  localparam int C_MAX_A     = (C_RST_LOW > C_PRES_TAIL) ? C_RST_LOW : C_PRES_TAIL;
  localparam int C_MAX       = (C_MAX_A > C_SLOT) ? C_MAX_A : C_SLOT;
  localparam int TW          = $clog2(C_MAX + 1);

  ow_state_e         st_q, st_d;
  ow_op_e            op_q;
  logic              rbit_q, pres_q;
  logic              busy_q, done_q, pull_q, pres_out_q;
  logic [DATA_W-1:0] rd_data_q;

  logic              bus_s;
  logic              tmo, ld;
  logic [TW-1:0]     ld_val;
  logic              sh_load, sh_shift, sh_lsb, sh_full;
  logic [DATA_W-1:0] sh_data;
  logic              fin, smp_bit, smp_pres, start_rd;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(bus_i), .q_o(bus_s)
  );

  ow_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load_i(ld), .val_i(ld_val), .zero_o(tmo)
  );

  ow_shifter #(.BITS(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(sh_load), .load_val_i(wr_data_i),
    .shift_i(sh_shift), .in_bit_i(rbit_q), .lsb_o(sh_lsb),
    .full_o(sh_full), .data_o(sh_data)
  );

  assign start_rd = (op_i == OP_READ);

  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    ld_val   = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    fin      = 1'b0;
    smp_bit  = 1'b0;
    smp_pres = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (op_i == OP_RESET) begin
            st_d   = ST_RST_LOW;
            ld     = 1'b1;
            ld_val = TW'(C_RST_LOW - 1);
          end else if (op_i == OP_WRITE || op_i == OP_READ) begin
            st_d    = ST_BIT_LOW;
            ld      = 1'b1;
            sh_load = 1'b1;
            if (start_rd)          ld_val = TW'(C_RD_LOW - 1);
            else if (wr_data_i[0]) ld_val = TW'(C_WR1_LOW - 1);
            else                   ld_val = TW'(C_SLOT - 1);
          end
        end
      end
      ST_RST_LOW: if (tmo) begin
        st_d   = ST_RST_WAIT;
        ld     = 1'b1;
        ld_val = TW'(C_PRES_SMP - 1);
      end
      ST_RST_WAIT: if (tmo) begin
        smp_pres = 1'b1;
        st_d     = ST_RST_TAIL;
        ld       = 1'b1;
        ld_val   = TW'(C_PRES_TAIL - 1);
      end
      ST_RST_TAIL: if (tmo) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      ST_BIT_LOW: if (tmo) begin
        ld = 1'b1;
        if (op_q == OP_READ) begin
          st_d   = ST_RD_WAIT;
          ld_val = TW'(C_RD_SMP - 1);
        end else if (sh_lsb) begin
          st_d   = ST_BIT_HIGH;
          ld_val = TW'(C_WR1_HIGH - 1);
        end else begin
          st_d     = ST_RECOV;
          ld_val   = TW'(C_RECOV - 1);
          sh_shift = 1'b1;
        end
      end
      ST_RD_WAIT: if (tmo) begin
        smp_bit = 1'b1;
        st_d    = ST_BIT_HIGH;
        ld      = 1'b1;
        ld_val  = TW'(C_RD_TAIL - 1);
      end
      ST_BIT_HIGH: if (tmo) begin
        st_d     = ST_RECOV;
        ld       = 1'b1;
        ld_val   = TW'(C_RECOV - 1);
        sh_shift = 1'b1;
      end
      ST_RECOV: if (tmo) begin
        if (sh_full) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end else begin
          st_d = ST_BIT_LOW;
          ld   = 1'b1;
          if (op_q == OP_READ) ld_val = TW'(C_RD_LOW - 1);
          else if (sh_lsb)     ld_val = TW'(C_WR1_LOW - 1);
          else                 ld_val = TW'(C_SLOT - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_NONE;
      rbit_q     <= 1'b0;
      pres_q     <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      pull_q     <= 1'b0;
      pres_out_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      st_q   <= st_d;
      busy_q <= (st_d != ST_IDLE);
      done_q <= fin;
      pull_q <= pulls_low(st_d);
      if (st_q == ST_IDLE && start_i) op_q <= ow_op_e'(op_i);
      if (smp_bit)  rbit_q <= bus_s;
      if (smp_pres) pres_q <= ~bus_s;
      if (fin && op_q == OP_READ)  rd_data_q  <= sh_data;
      if (fin && op_q == OP_RESET) pres_out_q <= pres_q;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign bus_pull_o = pull_q;
  assign rd_data_o  = rd_data_q;
  assign presence_o = pres_out_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  assert_rd_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data_o) |-> done_o);
  assert_pres_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(presence_o) |-> done_o);
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_pull_o);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(op_q));
endmodule

// File: tb/onewire_master_tb.sv
module onewire_master_tb;
  // compressed time base: 5 clock cycles stand for one microsecond
  localparam int CLK_HZ  = 5_000_000;
  localparam int US      = CLK_HZ / 1_000_000;
  localparam int RST_CYC = 480 * US;
  localparam int W1_CYC  = 2 * US;
  localparam int W0_CYC  = 60 * US;
  localparam int RD_CYC  = 2 * US;
  localparam int SLOT    = 60 * US;
  localparam int RECOV   = 5 * US;
  localparam int WSAMP   = 15 * US;
  localparam int HOLD    = 15 * US;
  localparam int PRES_ON = 15 * US;
  localparam int PRES_OFF= 135 * US;
  localparam int DONE_AFTER_REL = (60 + 420) * US;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] wr_data_i;
  logic       busy_o, done_o, presence_o, bus_pull_o;
  logic [7:0] rd_data_o;
  logic       dev_pull;
  wire        bus = !(bus_pull_o || dev_pull);

  int checks = 0;
  int fails  = 0;

  // device model state
  logic       rd_mode = 1'b0;
  logic       dev_present = 1'b0;
  logic [7:0] dev_byte = 8'h00;
  logic [7:0] wbits;
  int         lw [0:15];
  int         slot_n = 0;
  int         min_gap, min_period;
  int         low_c = 0, rel_c = 0, since_rise = 0;
  int         hold = 0, pres_t = 0;
  logic       pres_active = 1'b0;
  logic       prev_pull = 1'b0;

  always #10 clk = ~clk;

  onewire_master #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o),
    .presence_o(presence_o), .bus_pull_o(bus_pull_o), .bus_i(bus)
  );

  // bus device model and line timing monitor, evaluated on falling clock edges
  initial begin : device
    dev_pull = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_pull_o && !prev_pull) begin
        if (slot_n > 0) begin
          if (since_rise < min_period) min_period = since_rise;
          if (rel_c < min_gap) min_gap = rel_c;
        end
        since_rise = 0;
        rel_c = 0;
        if (rd_mode && slot_n < 8 && !dev_byte[slot_n]) hold = HOLD;
        slot_n++;
      end
      if (!bus_pull_o && prev_pull) begin
        if (slot_n >= 1 && slot_n <= 16) lw[slot_n-1] = low_c;
        if (low_c >= RST_CYC) begin
          pres_active = 1'b1;
          pres_t = 0;
        end
        low_c = 0;
        rel_c = 0;
      end
      if (bus_pull_o) low_c++; else rel_c++;
      since_rise++;
      if (since_rise == WSAMP && slot_n >= 1 && slot_n <= 8) wbits[slot_n-1] = bus;
      if (pres_active) pres_t++;
      dev_pull = (hold > 0) ||
                 (pres_active && dev_present && pres_t >= PRES_ON && pres_t < PRES_OFF);
      if (hold > 0) hold--;
      if (pres_t >= PRES_OFF) pres_active = 1'b0;
      prev_pull = bus_pull_o;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_monitor();
    slot_n = 0;
    min_gap = 1 << 30;
    min_period = 1 << 30;
    for (int i = 0; i < 16; i++) lw[i] = 0;
    wbits = 8'h00;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    start_i = 1'b1; op_i = op; wr_data_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // waits for done, then checks its one-cycle width and the busy fall (R9)
  task automatic wait_done(output int rel_at_done);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    rel_at_done = rel_c;
    chk(done_o, "R9 done seen", done_o, 1);
    chk(!busy_o, "R9 busy low with done", busy_o, 0);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
  endtask

  task automatic t_reset_state();
    chk(!busy_o && !done_o && !bus_pull_o, "R10 idle flags", {busy_o, done_o, bus_pull_o}, 0);
    chk(rd_data_o == 8'h00, "R10 rd_data", rd_data_o, 0);
    chk(!presence_o, "R10 presence", presence_o, 0);
  endtask

  task automatic t_reset(input logic present);
    int rel;
    logic [7:0] rd_before = rd_data_o;
    clear_monitor();
    dev_present = present;
    rd_mode = 1'b0;
    issue(2'b00, 8'h00);
    wait_done(rel);
    chk(lw[0] == RST_CYC, "R1 reset low width", lw[0], RST_CYC);
    chk(slot_n == 1, "R1 single low pulse", slot_n, 1);
    chk(presence_o == present, "R2 presence", presence_o, present);
    chk(rel >= DONE_AFTER_REL - 3 && rel <= DONE_AFTER_REL + 3, "R2 release to done", rel, DONE_AFTER_REL);
    chk(rd_data_o == rd_before, "R9 rd_data kept on reset", rd_data_o, rd_before);
  endtask

  task automatic t_write(input logic [7:0] b);
    int rel;
    logic [7:0] rd_before = rd_data_o;
    logic pres_before = presence_o;
    clear_monitor();
    rd_mode = 1'b0;
    issue(2'b01, b);
    wait_done(rel);
    chk(slot_n == 8, "R5 eight write slots", slot_n, 8);
    chk(wbits == b, "R5 LSB-first write byte", wbits, b);
    for (int i = 0; i < 8; i++)
      chk(lw[i] == (b[i] ? W1_CYC : W0_CYC), "R3 write low width", lw[i], b[i] ? W1_CYC : W0_CYC);
    chk(min_period >= SLOT, "R3 slot spacing", min_period, SLOT);
    chk(min_gap >= RECOV, "R6 recovery gap", min_gap, RECOV);
    chk(rd_data_o == rd_before, "R9 rd_data kept on write", rd_data_o, rd_before);
    chk(presence_o == pres_before, "R9 presence kept on write", presence_o, pres_before);
    chk(!bus_pull_o, "R7 released when idle", bus_pull_o, 0);
  endtask

  task automatic t_read(input logic [7:0] b);
    int rel;
    logic pres_before = presence_o;
    clear_monitor();
    rd_mode = 1'b1;
    dev_byte = b;
    issue(2'b10, 8'hFF);
    wait_done(rel);
    rd_mode = 1'b0;
    chk(rd_data_o == b, "R5 read byte", rd_data_o, b);
    chk(slot_n == 8, "R5 eight read slots", slot_n, 8);
    chk(lw[0] == RD_CYC, "R4 read low width", lw[0], RD_CYC);
    chk(min_period >= SLOT, "R4 read slot length", min_period, SLOT);
    chk(min_gap >= RECOV, "R6 recovery gap read", min_gap, RECOV);
    chk(presence_o == pres_before, "R9 presence kept on read", presence_o, pres_before);
  endtask

  task automatic t_start_ignored();
    int rel;
    clear_monitor();
    dev_present = 1'b0;
    issue(2'b00, 8'h00);
    repeat (100) @(negedge clk);
    issue(2'b01, 8'h00);
    wait_done(rel);
    chk(presence_o == 1'b0, "R8 reset result kept", presence_o, 0);
    repeat (400) @(negedge clk);
    chk(slot_n == 1, "R8 no write after busy start", slot_n, 1);
    clear_monitor();
    issue(2'b11, 8'h00);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R8 op 11 ignored busy", busy_o, 0);
    chk(slot_n == 0, "R8 op 11 no pulse", slot_n, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    rst = 1'b1; start_i = 1'b0; op_i = 2'b00; wr_data_i = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_reset(1'b1);
    t_reset(1'b0);
    t_reset(1'b1);
    t_write(8'hA5);
    t_write(8'h3C);
    t_read(8'h5A);
    t_read(8'hC3);
    t_start_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule